// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level, short-descriptor translation table out of memory. A requester presents the virtual address, the value of the table base register to use, a flag saying which of the two base registers it is, and a 3-bit table-size field. The walker then issues one or two single-word reads on a plain memory read port. It decodes each descriptor and reports the outcome with a one-cycle `done` pulse. The outcome is either a physical address with its mapping kind, cacheable/bufferable/shareable bits and three access-permission bits, or a translation fault.

The walker takes one request at a time. Its state machine has six states. IDLE accepts a request. From IDLE, a request whose index is outside the allowed range goes straight to DONE, and any other request goes to L1_READ. L1_READ issues the first-level read and moves to L1_WAIT. L1_WAIT waits for the read data, then goes either to DONE (fault, section or supersection) or to L2_READ (table pointer). L2_READ issues the second-level read and moves to L2_WAIT. L2_WAIT waits for the data and moves to DONE. DONE pulses `done` and returns to IDLE.

The first-level index is virtual address bits [31:20], with one word per 1 MB. The second-level index is bits [19:12], giving 256 words per second-level table.

Top module: `tw_walker`

## Requirements
- R1: `req_ready` is 1 only in IDLE. A request is taken when `req_valid` and `req_ready` are both 1. `done` is high for exactly one cycle per request, and `req_ready` is 0 while `done` is high.
- R2: With `req_base_sel`=0 the first-level read address is (`req_base` with bits [13-N:0] cleared) OR (va[31:20] shifted left by 2). With `req_base_sel`=1 the address uses `req_base` with bits [13:0] cleared and no index limit.
- R3: With `req_base_sel`=0, an index va[31:20] above 0xFFF>>N gives `res_fault`=1 and issues no memory read.
- R4: A first-level descriptor with bits [1:0]=00 gives `res_fault`=1 after exactly one read. Each read is a single-cycle `mem_req` pulse with a word-aligned address.
- R5: A first-level descriptor with bit 1 set and bit 18 clear is a section, `res_kind`=0. `res_pa` is {desc[31:20], va[19:0]}.
- R6: A first-level descriptor with bits 1 and 18 set is a supersection, `res_kind`=1. `res_pa` is {desc[31:24], va[23:0]}.
- R7: A first-level descriptor with bits [1:0]=01 is a table pointer. The second read goes to {desc[31:10], va[19:12], 2'b00}.
- R8: A second-level descriptor with bits [1:0]=01 is a large page, `res_kind`=2. `res_pa` is {desc[31:16], va[15:0]}.
- R9: A second-level descriptor with bit 1 set is a small page, `res_kind`=3. `res_pa` is {desc[31:12], va[11:0]}.
- R10: A second-level descriptor with bits [1:0]=00 gives `res_fault`=1 after exactly two reads.
- R11: For first-level mappings, `res_c`=bit 3, `res_b`=bit 2, `res_s`=bit 16 and `res_ap`={bit 15, bits 11:10}.
- R12: For second-level mappings, `res_c`=bit 3, `res_b`=bit 2, `res_s`=bit 10 and `res_ap`={bit 9, bits 5:4}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Virtual address |
| req_base | input | 32 | Table base register value |
| req_base_sel | input | 1 | 0: size-limited base, 1: unlimited base |
| req_n | input | 3 | Table-size field N |
| mem_req | output | 1 | One-cycle read strobe |
| mem_addr | output | 32 | Read word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Result valid pulse |
| res_fault | output | 1 | Translation fault |
| res_kind | output | 2 | 0 section, 1 supersection, 2 large page, 3 small page |
| res_pa | output | 32 | Physical address |
| res_c | output | 1 | Cacheable bit |
| res_b | output | 1 | Bufferable bit |
| res_s | output | 1 | Shareable bit |
| res_ap | output | 3 | Access permission {AP2, AP1, AP0} |

## Verification
The embedded assertions check several properties on every cycle. `done` is a single-cycle pulse that never coincides with `req_ready`. Each read strobe is one cycle long and word aligned. An out-of-range request reaches DONE with a fault and issues no read. For sections and small pages, the pass-through low address bits equal the latched virtual address. The directed scenarios cover what the properties cannot see: the exact read addresses under different N and base choices, the high physical bits and attribute positions of each of the four mapping kinds, and the number of reads made before each kind of fault.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int ADDR_W   = 32;
    localparam int L1_IDX_W = 12;
    localparam int L2_IDX_W = 8;
    localparam int N_W      = 3;

    typedef enum logic [1:0] {
        KIND_SECT  = 2'd0,
        KIND_SUPER = 2'd1,
        KIND_LARGE = 2'd2,
        KIND_SMALL = 2'd3
    } tw_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_READ,
        ST_L1_WAIT,
        ST_L2_READ,
        ST_L2_WAIT,
        ST_DONE
    } tw_state_e;

    typedef struct packed {
        logic              fault;
        tw_kind_e          kind;
        logic [ADDR_W-1:0] pa;
        logic              c;
        logic              b;
        logic              s;
        logic [2:0]        ap;
    } tw_result_t;
endpackage

// File: rtl/tw_l1_addr.sv
module tw_l1_addr
    import tw_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int IW   = L1_IDX_W,
    parameter int NW   = N_W
) (
    input  logic [AW-1:0] base,
    input  logic          base_sel,
    input  logic [NW-1:0] n,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] entry_addr,
    output logic          out_of_range
);
    // base bits below this position are cleared for the full-size table
    localparam int FULL_LOW = IW + 2;
    localparam int SH_W     = $clog2(FULL_LOW + 1);

    logic [SH_W-1:0] low_bits;
    logic [AW-1:0]   base_mask;
    logic [IW-1:0]   idx_limit;

    always_comb begin
        if (base_sel) begin
            low_bits  = SH_W'(FULL_LOW);
            idx_limit = {IW{1'b1}};
        end else begin
            low_bits  = SH_W'(FULL_LOW) - SH_W'(n);
            idx_limit = {IW{1'b1}} >> n;
        end
        base_mask    = {AW{1'b1}} << low_bits;
        out_of_range = (idx > idx_limit);
        entry_addr   = (base & base_mask) | {{(AW-IW-2){1'b0}}, idx, 2'b00};
    end
endmodule

// File: rtl/tw_desc_decode.sv
module tw_desc_decode
    import tw_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          level2,
    input  logic [31:0]   desc,
    input  logic [AW-1:0] va,
    output tw_result_t    res,
    output logic          is_table
);
    always_comb begin
        res      = '0;
        is_table = 1'b0;
        res.c    = desc[3];
        res.b    = desc[2];
        if (!level2) begin
            res.s  = desc[16];
            res.ap = {desc[15], desc[11:10]};
            if (desc[1:0] == 2'b00) begin
                res.fault = 1'b1;
            end else if (desc[1]) begin
                if (desc[18]) begin
                    res.kind = KIND_SUPER;
                    res.pa   = {desc[31:24], va[23:0]};
                end else begin
                    res.kind = KIND_SECT;
                    res.pa   = {desc[31:20], va[19:0]};
                end
            end else begin
                is_table = 1'b1;
            end
        end else begin
            res.s  = desc[10];
            res.ap = {desc[9], desc[5:4]};
            if (desc[1:0] == 2'b00) begin
                res.fault = 1'b1;
            end else if (desc[1:0] == 2'b01) begin
                res.kind = KIND_LARGE;
                res.pa   = {desc[31:16], va[15:0]};
            end else begin
                res.kind = KIND_SMALL;
                res.pa   = {desc[31:12], va[11:0]};
            end
        end
        if (res.fault || is_table) begin
            res.c  = 1'b0;
            res.b  = 1'b0;
            res.s  = 1'b0;
            res.ap = '0;
        end
    end
endmodule

// File: rtl/tw_walker.sv
module tw_walker
    import tw_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int IW1 = L1_IDX_W,
    parameter int IW2 = L2_IDX_W,
    parameter int NW  = N_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_va,
    input  logic [AW-1:0] req_base,
    input  logic          req_base_sel,
    input  logic [NW-1:0] req_n,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          done,
    output logic          res_fault,
    output logic [1:0]    res_kind,
    output logic [AW-1:0] res_pa,
    output logic          res_c,
    output logic          res_b,
    output logic          res_s,
    output logic [2:0]    res_ap
);
    localparam int L2_LO = 2;
    localparam int L2_HI = L2_LO + IW2;
    localparam int VA_L2 = AW - IW1 - IW2;

    tw_state_e  state, state_nx;
    logic [AW-1:0] va_q, l1_addr_q, l2_addr_q;
    tw_result_t    res_q;

    logic [AW-1:0] l1_addr;
    logic          oor;
    tw_result_t    dec_res;
    logic          dec_table;
    logic          accept;

    assign accept = req_valid && req_ready;

    tw_l1_addr #(.AW(AW), .IW(IW1), .NW(NW)) u_l1 (
        .base         (req_base),
        .base_sel     (req_base_sel),
        .n            (req_n),
        .idx          (req_va[AW-1 -: IW1]),
        .entry_addr   (l1_addr),
        .out_of_range (oor)
    );

    tw_desc_decode #(.AW(AW)) u_dec (
        .level2   (state == ST_L2_WAIT),
        .desc     (mem_rdata),
        .va       (va_q),
        .res      (dec_res),
        .is_table (dec_table)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = oor ? ST_DONE : ST_L1_READ;
            ST_L1_READ: state_nx = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rvalid) state_nx = dec_table ? ST_L2_READ : ST_DONE;
            ST_L2_READ: state_nx = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rvalid) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // request latches and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            l1_addr_q <= '0;
            l2_addr_q <= '0;
            res_q     <= '0;
        end else begin
            if (state == ST_IDLE && accept) begin
                va_q      <= req_va;
                l1_addr_q <= l1_addr;
                if (oor) begin
                    res_q       <= '0;
                    res_q.fault <= 1'b1;
                end
            end
            if (state == ST_L1_WAIT && mem_rvalid) begin
                if (dec_table)
                    l2_addr_q <= {mem_rdata[AW-1:L2_HI], va_q[AW-IW1-1 -: IW2], 2'b00};
                else
                    res_q <= dec_res;
            end
            if (state == ST_L2_WAIT && mem_rvalid)
                res_q <= dec_res;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_addr  = '0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:    req_ready = 1'b1;
            ST_L1_READ: begin mem_req = 1'b1; mem_addr = l1_addr_q; end
            ST_L2_READ: begin mem_req = 1'b1; mem_addr = l2_addr_q; end
            ST_DONE:    done = 1'b1;
            default:    ;
        endcase
    end

    assign res_fault = res_q.fault;
    assign res_kind  = res_q.kind;
    assign res_pa    = res_q.pa;
    assign res_c     = res_q.c;
    assign res_b     = res_q.b;
    assign res_s     = res_q.s;
    assign res_ap    = res_q.ap;

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1
    ready_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);
    // R3
    oor_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && oor) |=> (done && res_fault && !mem_req));
    // R4
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R4
    read_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    // R5
    sect_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !res_fault && res_kind == KIND_SECT) |-> (res_pa[AW-IW1-1:0] == va_q[AW-IW1-1:0]));
    // R9
    small_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !res_fault && res_kind == KIND_SMALL) |-> (res_pa[VA_L2-1:0] == va_q[VA_L2-1:0]));
endmodule

// File: tb/tb_tw_walker.sv
module tb_tw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0, req_base = '0;
    logic        req_base_sel = 1'b0;
    logic [2:0]  req_n = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, res_fault, res_c, res_b, res_s;
    logic [1:0]  res_kind;
    logic [31:0] res_pa;
    logic [2:0]  res_ap;

    always #5 clk = ~clk;

    tw_walker dut (.*);

    int n_chk = 0, n_fail = 0;
    int cycles = 0;

    // sparse memory model
    logic [31:0] m_addr [16];
    logic [31:0] m_data [16];
    int          m_cnt = 0;
    int          reads = 0;
    logic [31:0] rd_log [2];
    int          lat = 1;
    int          pend = 0, cnt = 0;
    logic [31:0] pend_addr = '0;

    function automatic logic [31:0] lookup(input logic [31:0] a);
        lookup = 32'h0;
        for (int i = 0; i < m_cnt; i++) if (m_addr[i] == a) lookup = m_data[i];
    endfunction

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        m_addr[m_cnt] = a;
        m_data[m_cnt] = d;
        m_cnt++;
    endtask

    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend != 0) begin
            if (cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= lookup(pend_addr);
                pend = 0;
            end else cnt--;
        end
        if (mem_req) begin
            if (reads < 2) rd_log[reads] = mem_addr;
            reads++;
            pend = 1;
            cnt = lat - 1;
            pend_addr = mem_addr;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] base,
                        input logic sel, input logic [2:0] n);
        int t;
        reads = 0;
        @(negedge clk);
        req_va = va; req_base = base; req_base_sel = sel; req_n = n; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 ready low after accept", {31'b0, req_ready}, 32'h0);
        t = 0;
        while (!done && t < 40) begin @(negedge clk); t++; end
        check("R1 done seen", {31'b0, done}, 32'h1);
        check("R1 ready low during done", {31'b0, req_ready}, 32'h0);
    endtask

    task automatic expect_map(input string req, input logic [31:0] pa, input logic [1:0] kind,
                              input logic c, input logic b, input logic s, input logic [2:0] ap);
        check({req, " fault"}, {31'b0, res_fault}, 32'h0);
        check({req, " pa"}, res_pa, pa);
        check({req, " kind"}, {30'b0, res_kind}, {30'b0, kind});
        check({req, " cbs"}, {29'b0, res_c, res_b, res_s}, {29'b0, c, b, s});
        check({req, " ap"}, {29'b0, res_ap}, {29'b0, ap});
    endtask

    task automatic t_reset();
        check("R1 reset ready", {31'b0, req_ready}, 32'h1);
        check("R1 reset done", {31'b0, done}, 32'h0);
        check("R4 reset mem_req", {31'b0, mem_req}, 32'h0);
    endtask

    task automatic t_section();
        m_cnt = 0; lat = 1;
        put(32'h0000_448C, 32'h8761_8C0A);
        walk(32'h1234_5678, 32'h0000_4000, 1'b0, 3'd0);
        check("R2 l1 addr", rd_log[0], 32'h0000_448C);
        check("R4 one read", reads, 1);
        expect_map("R5 R11 section", 32'h8764_5678, 2'd0, 1'b1, 1'b0, 1'b1, 3'b111);
        @(negedge clk);
        check("R1 done one cycle", {31'b0, done}, 32'h0);
        check("R1 ready back", {31'b0, req_ready}, 32'h1);
    endtask

    task automatic t_super();
        m_cnt = 0; lat = 3;
        put(32'h0008_2AF0, 32'h5504_0006);
        walk(32'hABCD_EF01, 32'h0008_0000, 1'b0, 3'd0);
        check("R2 l1 addr super", rd_log[0], 32'h0008_2AF0);
        expect_map("R6 R11 super", 32'h55CD_EF01, 2'd1, 1'b0, 1'b1, 1'b0, 3'b000);
    endtask

    task automatic t_small();
        m_cnt = 0; lat = 2;
        put(32'h0000_400C, 32'h0010_0401);
        put(32'h0010_0414, 32'h9ABC_D61A);
        walk(32'h0030_5ABC, 32'h0000_4000, 1'b0, 3'd0);
        check("R7 two reads", reads, 2);
        check("R7 l2 addr", rd_log[1], 32'h0010_0414);
        expect_map("R9 R12 small", 32'h9ABC_DABC, 2'd3, 1'b1, 1'b0, 1'b1, 3'b101);
    endtask

    task automatic t_large();
        m_cnt = 0; lat = 1;
        put(32'h0000_400C, 32'h0010_0401);
        put(32'h0010_05C4, 32'h1234_0005);
        walk(32'h0037_1234, 32'h0000_4000, 1'b0, 3'd0);
        check("R7 l2 addr large", rd_log[1], 32'h0010_05C4);
        expect_map("R8 R12 large", 32'h1234_1234, 2'd2, 1'b0, 1'b1, 1'b0, 3'b000);
    endtask

    task automatic t_faults();
        m_cnt = 0; lat = 1;
        walk(32'h0050_0000, 32'h0000_4000, 1'b0, 3'd0);
        check("R4 l1 fault", {31'b0, res_fault}, 32'h1);
        check("R4 l1 fault reads", reads, 1);
        put(32'h0000_4018, 32'h0020_0001);
        walk(32'h0060_0000, 32'h0000_4000, 1'b0, 3'd0);
        check("R10 l2 fault", {31'b0, res_fault}, 32'h1);
        check("R10 l2 fault reads", reads, 2);
    endtask

    task automatic t_limit();
        m_cnt = 0; lat = 1;
        walk(32'h4000_0000, 32'h0000_1000, 1'b0, 3'd2);
        check("R3 oor fault", {31'b0, res_fault}, 32'h1);
        check("R3 oor no read", reads, 0);
        put(32'h0000_1FFC, 32'h0030_0002);
        walk(32'h3FF1_2345, 32'h0000_1FFF, 1'b0, 3'd2);
        check("R2 N-masked addr", rd_log[0], 32'h0000_1FFC);
        check("R3 boundary ok", {31'b0, res_fault}, 32'h0);
        check("R5 boundary pa", res_pa, 32'h0031_2345);
        put(32'h0000_FFFC, 32'h0010_0002);
        walk(32'hFFF0_0000, 32'h0000_C123, 1'b1, 3'd7);
        check("R2 base1 addr", rd_log[0], 32'h0000_FFFC);
        check("R2 base1 no limit", {31'b0, res_fault}, 32'h0);
        check("R5 base1 pa", res_pa, 32'h0010_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_section();
        t_super();
        t_small();
        t_large();
        t_faults();
        t_limit();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected < 20000 cycles", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule